// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block keeps the transmit error count (TEC) and receive error count (REC) of a CAN protocol controller and turns them into the node's fault confinement state. The protocol engine feeds it one-cycle event pulses. An error pulse comes with the kind of error, whether the node was transmitting, and whether the node was driving an active error flag or an overload flag when the error was seen. Separate pulses report a transmission or a reception that completed without error. A further pulse reports that the bus-off recovery sequence has been observed.

The block applies the fault confinement rules to these events. A receiver that hits a bit error while driving its own flag takes a heavier penalty than one that sees a plain receive error. Every transmitter error costs 8. Each successful frame lowers the count by one. Both counters are registered and move one clock edge after the pulse that affects them. The three state flags are decoded from the registered counters. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `can_fault_conf`

## Requirements
- R1: A receiver error pulse (`err_pulse`=1, `err_as_tx`=0) with `err_kind`=0 (bit error) and `err_in_flag`=1 raises REC by 8 on the next clock edge.
- R2: Any other receiver error raises REC by 1. This covers `err_kind` 1 stuff, 2 form, 3 CRC and 4 acknowledge, and a bit error outside a flag.
- R3: A transmitter error pulse (`err_as_tx`=1) raises TEC by 8 for every error kind. An acknowledge error followed by a bit error in the node's own error flag therefore totals 16.
- R4: Receiver errors leave TEC unchanged. Transmitter errors leave REC unchanged.
- R5: `tx_ok` lowers TEC by 1 and `rx_ok` lowers REC by 1 when REC is at most 127. A counter at 0 stays at 0. A +8 penalty followed by one success therefore nets +7.
- R6: `rx_ok` with REC above 127 sets REC to 120.
- R7: When an error pulse and a success pulse arrive in the same cycle, the error is applied and the success is dropped.
- R8: `st_active` is 1 while both counters are at most 127. `st_passive` is 1 when either counter exceeds 127 and TEC is at most 255. At most one flag is 1 at a time.
- R9: `st_bus_off` is 1 when TEC exceeds 255. While it is set, error and success pulses change neither counter.
- R10: `recov_done` during bus-off clears both counters to 0. It has no effect outside bus-off.
- R11: Synchronous `rst` clears both counters, and the node is then error-active.
- R12: Both counters saturate at 511 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_pulse | input | 1 | One-cycle error event |
| err_kind | input | 3 | 0 bit, 1 stuff, 2 form, 3 CRC, 4 acknowledge |
| err_as_tx | input | 1 | Node was transmitter when the error was seen |
| err_in_flag | input | 1 | Node was driving an active error or overload flag |
| tx_ok | input | 1 | Transmission completed successfully |
| rx_ok | input | 1 | Reception completed successfully |
| recov_done | input | 1 | 128 runs of 11 recessive bits observed |
| tec | output | 9 | Transmit error count |
| rec | output | 9 | Receive error count |
| st_active | output | 1 | Error-active |
| st_passive | output | 1 | Error-passive |
| st_bus_off | output | 1 | Bus-off |

## Verification
The bench targets the distinction between a flag bit error and other receiver errors. A design that mixes them up would show REC moving by 1 where 8 is expected, or the other way round. It replays the +16 transmitter sequence and the net +7 sequence. It drives REC past 127 to check the jump to 120 on reception, because a plain decrement would leave the node error-passive. It also checks the floor at zero, the same-cycle collision between error and success, and the bus-off freeze. A design that kept counting in bus-off, or honoured recovery outside bus-off, would show counters diverging from the arithmetic model. A long pseudo-random sweep over every kind, role and flag combination compares both counters and all three flags after each event.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [2:0] {
    EK_BIT   = 3'd0,
    EK_STUFF = 3'd1,
    EK_FORM  = 3'd2,
    EK_CRC   = 3'd3,
    EK_ACK   = 3'd4
  } err_kind_e;
endpackage

// File: rtl/can_fc_sat_ctr.sv
module can_fc_sat_ctr #(
  parameter int W  = 9,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc_en,
  input  logic [IW-1:0] inc_amt,
  input  logic          dec_en,
  input  logic          load_en,
  input  logic [W-1:0]  load_val,
  output logic [W-1:0]  cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W:0] sum;
  assign sum = {1'b0, cnt} + (W+1)'(inc_amt);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc_en) begin
      cnt <= sum[W] ? MAXV : sum[W-1:0];
    end else if (load_en) begin
      cnt <= load_val;
    end else if (dec_en && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/can_fc_event_decode.sv
module can_fc_event_decode
  import can_fc_pkg::*;
#(
  parameter int IW          = 4,
  parameter int TX_PEN      = 8,
  parameter int RX_FLAG_PEN = 8,
  parameter int RX_PEN      = 1
) (
  input  logic          err_pulse,
  input  logic [2:0]    err_kind,
  input  logic          err_as_tx,
  input  logic          err_in_flag,
  input  logic          tx_ok,
  input  logic          rx_ok,
  input  logic          recov_done,
  input  logic          bus_off,
  input  logic          rec_high,
  output logic          tec_inc,
  output logic [IW-1:0] tec_amt,
  output logic          tec_dec,
  output logic          rec_inc,
  output logic [IW-1:0] rec_amt,
  output logic          rec_dec,
  output logic          rec_load,
  output logic          clr_all
);
  logic live;
  logic flag_bit_err;

  always_comb begin
    live         = !bus_off;
    flag_bit_err = err_in_flag && (err_kind_e'(err_kind) == EK_BIT);
    tec_inc      = live && err_pulse && err_as_tx;
    tec_amt      = IW'(TX_PEN);
    rec_inc      = live && err_pulse && !err_as_tx;
    rec_amt      = flag_bit_err ? IW'(RX_FLAG_PEN) : IW'(RX_PEN);
    tec_dec      = live && !err_pulse && tx_ok;
    rec_load     = live && !err_pulse && rx_ok && rec_high;
    rec_dec      = live && !err_pulse && rx_ok && !rec_high;
    clr_all      = bus_off && recov_done;
  end
endmodule

// File: rtl/can_fc_state_decode.sv
module can_fc_state_decode #(
  parameter int W           = 9,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255
) (
  input  logic [W-1:0] tec,
  input  logic [W-1:0] rec,
  output logic         rec_high,
  output logic         st_active,
  output logic         st_passive,
  output logic         st_bus_off
);
  localparam logic [W-1:0] P_LIM = W'(PASSIVE_LIM);
  localparam logic [W-1:0] B_LIM = W'(BUSOFF_LIM);

  always_comb begin
    rec_high   = rec > P_LIM;
    st_bus_off = tec > B_LIM;
    st_active  = (tec <= P_LIM) && (rec <= P_LIM);
    st_passive = !st_active && !st_bus_off;
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int CNT_W       = 9,
  parameter int PEN_W       = 4,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255,
  parameter int TX_PEN      = 8,
  parameter int RX_FLAG_PEN = 8,
  parameter int RX_PEN      = 1,
  parameter int RX_REENTRY  = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_pulse,
  input  logic [2:0]       err_kind,
  input  logic             err_as_tx,
  input  logic             err_in_flag,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             recov_done,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic             st_active,
  output logic             st_passive,
  output logic             st_bus_off
);
  localparam logic [CNT_W-1:0] REENTRY_V = CNT_W'(RX_REENTRY);

  logic             tec_inc, tec_dec, rec_inc, rec_dec, rec_load, clr_all;
  logic [PEN_W-1:0] tec_amt, rec_amt;
  logic             rec_high;

  can_fc_state_decode #(
    .W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
  ) u_state (
    .tec(tec), .rec(rec), .rec_high(rec_high),
    .st_active(st_active), .st_passive(st_passive), .st_bus_off(st_bus_off)
  );

  can_fc_event_decode #(
    .IW(PEN_W), .TX_PEN(TX_PEN), .RX_FLAG_PEN(RX_FLAG_PEN), .RX_PEN(RX_PEN)
  ) u_evt (
    .err_pulse(err_pulse), .err_kind(err_kind), .err_as_tx(err_as_tx),
    .err_in_flag(err_in_flag), .tx_ok(tx_ok), .rx_ok(rx_ok),
    .recov_done(recov_done), .bus_off(st_bus_off), .rec_high(rec_high),
    .tec_inc(tec_inc), .tec_amt(tec_amt), .tec_dec(tec_dec),
    .rec_inc(rec_inc), .rec_amt(rec_amt), .rec_dec(rec_dec),
    .rec_load(rec_load), .clr_all(clr_all)
  );

  can_fc_sat_ctr #(.W(CNT_W), .IW(PEN_W)) u_tec (
    .clk(clk), .rst(rst), .clr(clr_all),
    .inc_en(tec_inc), .inc_amt(tec_amt), .dec_en(tec_dec),
    .load_en(1'b0), .load_val('0), .cnt(tec)
  );

  can_fc_sat_ctr #(.W(CNT_W), .IW(PEN_W)) u_rec (
    .clk(clk), .rst(rst), .clr(clr_all),
    .inc_en(rec_inc), .inc_amt(rec_amt), .dec_en(rec_dec),
    .load_en(rec_load), .load_val(REENTRY_V), .cnt(rec)
  );
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             err_pulse,
  input logic [2:0]       err_kind,
  input logic             err_as_tx,
  input logic             err_in_flag,
  input logic             tx_ok,
  input logic             rx_ok,
  input logic             recov_done,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic             st_active,
  input logic             st_passive,
  input logic             st_bus_off
);
  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  assert_flag_bit_R1: assert property (@(posedge clk) disable iff (rst || !started)
    (err_pulse && !err_as_tx && err_in_flag && err_kind == 3'd0 && !st_bus_off && rec < 9'd400)
    |=> rec == $past(rec) + 9'd8);

  assert_tx_pen_R3: assert property (@(posedge clk) disable iff (rst || !started)
    (err_pulse && err_as_tx && !st_bus_off && tec < 9'd400) |=> tec == $past(tec) + 9'd8);

  assert_tec_hold_R4: assert property (@(posedge clk) disable iff (rst || !started)
    (err_pulse && !err_as_tx && !recov_done) |=> tec == $past(tec));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst || !started)
    (tx_ok && !err_pulse && tec == '0) |=> tec == '0);

  assert_reentry_R6: assert property (@(posedge clk) disable iff (rst || !started)
    (rx_ok && !err_pulse && !st_bus_off && rec > 9'd127) |=> rec == 9'd120);

  assert_one_state_R8: assert property (@(posedge clk) disable iff (rst)
    $countones({st_active, st_passive, st_bus_off}) == 1);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (rst || !started)
    (st_bus_off && !recov_done) |=> $stable(tec) && $stable(rec));

  assert_recover_R10: assert property (@(posedge clk) disable iff (rst || !started)
    (st_bus_off && recov_done) |=> tec == '0 && rec == '0);

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> tec == '0 && rec == '0 && st_active);
endmodule

bind can_fault_conf can_fault_conf_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/can_fault_conf_tb.sv
module can_fault_conf_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       err_pulse = 0, err_as_tx = 0, err_in_flag = 0;
  logic [2:0] err_kind = 0;
  logic       tx_ok = 0, rx_ok = 0, recov_done = 0;
  logic [8:0] tec, rec;
  logic       st_active, st_passive, st_bus_off;

  can_fault_conf u_dut (
    .clk(clk), .rst(rst), .err_pulse(err_pulse), .err_kind(err_kind),
    .err_as_tx(err_as_tx), .err_in_flag(err_in_flag), .tx_ok(tx_ok),
    .rx_ok(rx_ok), .recov_done(recov_done), .tec(tec), .rec(rec),
    .st_active(st_active), .st_passive(st_passive), .st_bus_off(st_bus_off)
  );

  int n_chk = 0, n_err = 0;
  int m_tec = 0, m_rec = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    int e_state;
    e_state = (m_tec > 255) ? 4 : ((m_tec <= 127 && m_rec <= 127) ? 1 : 2);
    chk(req, "tec", int'(tec), m_tec);
    chk(req, "rec", int'(rec), m_rec);
    chk(req, "state{busoff,passive,active}", int'({st_bus_off, st_passive, st_active}), e_state);
  endtask

  task automatic model(input bit e, input int kind, input bit as_tx, input bit flag,
                       input bit tok, input bit rok, input bit rc);
    if (m_tec > 255) begin
      if (rc) begin m_tec = 0; m_rec = 0; end
    end else if (e) begin
      if (as_tx) m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
      else begin
        int add;
        add = (flag && kind == 0) ? 8 : 1;
        m_rec = (m_rec + add > 511) ? 511 : m_rec + add;
      end
    end else begin
      if (tok && m_tec > 0) m_tec--;
      if (rok) begin
        if (m_rec > 127) m_rec = 120;
        else if (m_rec > 0) m_rec--;
      end
    end
  endtask

  task automatic step(input bit e, input int kind, input bit as_tx, input bit flag,
                      input bit tok, input bit rok, input bit rc, input string req);
    @(negedge clk);
    err_pulse = e; err_kind = 3'(kind); err_as_tx = as_tx; err_in_flag = flag;
    tx_ok = tok; rx_ok = rok; recov_done = rc;
    @(negedge clk);
    err_pulse = 0; tx_ok = 0; rx_ok = 0; recov_done = 0;
    model(e, kind, as_tx, flag, tok, rok, rc);
    compare(req);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    m_tec = 0; m_rec = 0;
    compare(req);
  endtask

  initial begin
    #(20 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset("R11 reset");
    // R3: ack error then bit error in own error flag, total 16
    step(1, 4, 1, 0, 0, 0, 0, "R3 ack");
    step(1, 0, 1, 1, 0, 0, 0, "R3 flag bit");
    // R2/R4: receiver form error, tec unchanged
    step(1, 2, 0, 0, 0, 0, 0, "R2 R4 form");
    // R1: receiver bit error in flag
    step(1, 0, 0, 1, 0, 0, 0, "R1 flag bit");
    step(1, 0, 0, 0, 0, 0, 0, "R2 bit outside flag");
    // R5: net +7 after success
    step(0, 0, 0, 0, 1, 1, 0, "R5 success");
    // R7: collision
    step(1, 0, 0, 1, 1, 1, 0, "R7 collision");
    // R10: recovery outside bus-off ignored
    step(0, 0, 0, 0, 0, 0, 1, "R10 ignored");
    do_reset("R11 reset2");
    step(0, 0, 0, 0, 1, 1, 0, "R5 floor");
    // R6/R8: rec beyond 127 then reentry
    for (int i = 0; i < 17; i++) step(1, 0, 0, 1, 0, 0, 0, "R8 rec climb");
    step(0, 0, 0, 0, 0, 1, 0, "R6 reentry");
    // R9: bus-off
    for (int i = 0; i < 32; i++) step(1, 4, 1, 0, 0, 0, 0, "R8 R9 tec climb");
    step(1, 2, 0, 0, 0, 0, 0, "R9 rx err frozen");
    step(0, 0, 0, 0, 1, 1, 0, "R9 success frozen");
    step(1, 0, 1, 1, 0, 0, 0, "R9 tx err frozen");
    step(0, 0, 0, 0, 0, 0, 1, "R10 recover");
    // R12: saturation of rec
    for (int i = 0; i < 66; i++) step(1, 0, 0, 1, 0, 0, 0, "R12 saturate");
    do_reset("R11 reset3");
    // sweep
    for (int i = 0; i < 6000; i++) begin
      bit e, as_tx, flag, tok, rok, rc;
      int kind;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      e = lfsr[0]; as_tx = lfsr[1]; flag = lfsr[2];
      kind = int'(lfsr[6:4]) % 5;
      tok = lfsr[7]; rok = lfsr[8];
      rc = (lfsr[11:9] == 3'd0);
      step(e, kind, as_tx, flag, tok, rok, rc, "R12 sweep");
      if (i % 700 == 699) do_reset("R11 sweep reset");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule